// File: doc/BRIEF.md
# Four-Phase Constant-Current PWM Chopper

This block generates the gate drive for the four windings of a unipolar two-phase stepping motor: phase A with its complement AB, and phase B with its complement BB. A free-running period timer divides the system clock down to the chopping rate, nominally 50 kHz and kept between 37.5 and 62.5 kHz in use. At the start of every period the block switches on each winding that the step sequencer marks as active. Each winding then stays on until its current comparator reports that the sensed current has risen above the microstep reference.

The comparator trip is held until the next period starts, so a noisy comparator cannot cause chatter inside one period. For a set number of cycles after each turn-on the comparator is ignored, which masks the switching spike. A winding and its complement are never driven together. A low global enable removes all gate drive at once. While enable is low the block does not react to its other inputs, and when enable returns a fresh period begins.

Top module: `phase_chopper`

## Requirements
- R1: While `rst_n` is low all four gate outputs are 0. The first clock edge after reset release, with `enable` high, is a period start.
- R2: Period starts recur every PERIOD = CLK_HZ / PWM_HZ clock edges (20 with the bench parameters). At each start, every armed winding is switched on.
- R3: The `phase_active` bits are sampled only at a period-start edge, with bit 0 = A, bit 1 = AB, bit 2 = B and bit 3 = BB. A change of `phase_active` during a period has no effect until the next start.
- R4: A winding whose active bit is 0 at a period start stays off for that whole period, whatever its comparator does.
- R5: When an on winding's comparator bit is 1 at a clock edge outside the blanking window, that winding turns off at that edge. It stays off until the next period start, even after the comparator returns to 0.
- R6: For BLANK_CYC clock edges after the turn-on edge (3 in the bench), the winding ignores its comparator bit.
- R7: A comparator trip affects only its own winding. The other gate outputs keep their values.
- R8: While `enable` is 0 every gate output is 0 in that same cycle, and changes to `phase_active` and `phase_trip` have no effect.
- R9: The first clock edge with `enable` high after a low period is a period start. It samples `phase_active` as it stands at that edge.
- R10: If both windings of one pair (A/AB or B/BB) are active at a period start, both stay off for that period. The other pair is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Global drive enable; 0 turns all gates off |
| phase_active | input | 4 | Winding select from the step sequencer (0=A, 1=AB, 2=B, 3=BB) |
| phase_trip | input | 4 | Per-winding comparator: 1 when current is above the reference |
| gate | output | 4 | Gate drive per winding, same bit order |

## Verification
A period start takes effect on the gates at that same edge, because only one register stage sits between the inputs and the gates. The bench reads the gates on the falling edge that follows that start edge, and counts every later edge from there. A comparator trip held from the start therefore shows as a 0 only after edge BLANK_CYC+1. The restart is due after edge PERIOD and not after edge PERIOD-1, so the bench samples on both sides of each boundary. The effect of `enable` is combinational, so it is checked one time step after `enable` is driven low, without waiting for an edge. Resumption is checked at the first falling edge after `enable` goes high again.

// File: rtl/chop_pkg.sv
// Package: shared constants for the four-winding chopper.
// Assumes windings are grouped in complementary pairs, with each pair
// occupying two adjacent bits: even bit = winding, odd bit = complement.
package chop_pkg;
    localparam int NUM_PAIRS  = 2;
    localparam int NUM_PHASES = 2 * NUM_PAIRS;

    // Bit positions of the windings inside every per-phase vector.
    typedef enum int {
        PH_A  = 0,
        PH_AB = 1,
        PH_B  = 2,
        PH_BB = 3
    } phase_idx_e;
endpackage

// File: rtl/chop_period_timer.sv
// Period timer: counts system clocks and flags the edge on which a new
// chopping period begins. Assumes CLK_HZ / PWM_HZ >= 2. While enable is
// low the counter parks on its last value, so the first enabled edge
// afterwards is a period start.
module chop_period_timer #(
    parameter int CLK_HZ = 50_000_000,
    parameter int PWM_HZ = 50_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    output logic start_o
);
    localparam int PERIOD = CLK_HZ / PWM_HZ;
    localparam int CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    // Advance the period counter, wrap at LAST, park on LAST when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LAST;
        end else if (!enable_i) begin
            cnt_q <= LAST;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // A start is the enabled edge on which the counter leaves LAST.
    assign start_o = enable_i && (cnt_q == LAST);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);  // R2

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && enable_i) |=> (cnt_q == '0 || !enable_i));  // R2

    AST_RESUME_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable_i) |-> start_o);  // R9
endmodule

// File: rtl/chop_pair_guard.sv
// Pair guard: turns the sequencer's active bits into arm bits, one pair
// at a time. If a winding and its complement are both requested, neither
// is armed. Assumes the pair layout that chop_pkg describes.
module chop_pair_guard #(
    parameter int PAIRS = chop_pkg::NUM_PAIRS
) (
    input  logic [2*PAIRS-1:0] active_i,
    output logic [2*PAIRS-1:0] arm_o
);
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        // Arm a winding only when its complement is not also requested.
        always_comb begin
            arm_o[2*p]   = active_i[2*p]   && !active_i[2*p+1];
            arm_o[2*p+1] = active_i[2*p+1] && !active_i[2*p];
        end
    end
endmodule

// File: rtl/chop_phase_gate.sv
// Single-winding gate state: switches on at a period start if armed,
// ignores the comparator for BLANK_CYC edges, then latches off on the
// first trip until the next period start. Assumes start_i is only high
// while enable_i is high. A low enable clears the state.
module chop_phase_gate #(
    parameter int BLANK_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic start_i,
    input  logic arm_i,
    input  logic trip_i,
    output logic gate_o
);
    localparam int BW = $clog2(BLANK_CYC + 2);
    localparam logic [BW-1:0] BLANK_LD = BW'(BLANK_CYC);

    logic          gate_q;
    logic [BW-1:0] blank_q;

    // Gate state and blanking countdown for one winding.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            gate_q  <= 1'b0;
            blank_q <= '0;
        end else if (start_i) begin
            gate_q  <= arm_i;
            blank_q <= BLANK_LD;
        end else if (blank_q != '0) begin
            blank_q <= blank_q - BW'(1);
        end else if (gate_q && trip_i) begin
            gate_q  <= 1'b0;
        end
    end

    assign gate_o = gate_q;

    AST_ON_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q) |-> $past(start_i));  // R3

    AST_INACTIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !arm_i) |=> !gate_q);  // R4

    AST_TRIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && blank_q == '0 && trip_i && !start_i) |=> !gate_q);  // R5

    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && blank_q != '0 && enable_i && !start_i) |=> gate_q);  // R6

    AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !gate_q);  // R8
endmodule

// File: rtl/phase_chopper.sv
// Top: fixed-frequency constant-current chopper for four unipolar windings.
// Assumes the comparator inputs are already synchronous to clk. Gate
// outputs are the registered per-winding state, masked at once by enable.
module phase_chopper #(
    parameter int CLK_HZ    = 50_000_000,
    parameter int PWM_HZ    = 50_000,
    parameter int BLANK_CYC = 25
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            enable,
    input  logic [chop_pkg::NUM_PHASES-1:0] phase_active,
    input  logic [chop_pkg::NUM_PHASES-1:0] phase_trip,
    output logic [chop_pkg::NUM_PHASES-1:0] gate
);
    localparam int NPH = chop_pkg::NUM_PHASES;

    logic           start;
    logic [NPH-1:0] arm;
    logic [NPH-1:0] gate_st;

    chop_period_timer #(
        .CLK_HZ (CLK_HZ),
        .PWM_HZ (PWM_HZ)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (enable),
        .start_o  (start)
    );

    chop_pair_guard #(
        .PAIRS (chop_pkg::NUM_PAIRS)
    ) u_guard (
        .active_i (phase_active),
        .arm_o    (arm)
    );

    for (genvar i = 0; i < NPH; i++) begin : g_phase
        chop_phase_gate #(
            .BLANK_CYC (BLANK_CYC)
        ) u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable_i (enable),
            .start_i  (start),
            .arm_i    (arm[i]),
            .trip_i   (phase_trip[i]),
            .gate_o   (gate_st[i])
        );
    end

    // Enable masks the drive immediately, without waiting for an edge.
    always_comb begin
        gate = enable ? gate_st : '0;
    end

    for (genvar p = 0; p < chop_pkg::NUM_PAIRS; p++) begin : g_excl
        AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate[2*p] && gate[2*p+1]));  // R10
    end

    AST_RESET_OFF: assert property (@(posedge clk)
        !rst_n |=> (gate_st == '0));  // R1
endmodule

// File: tb/sim_phase_chopper.sv
// Directed bench for phase_chopper: PERIOD = 20 cycles, blanking 3 edges.
module sim_phase_chopper;
    localparam int CLK_PERIOD = 10;
    localparam int PER        = 20;
    localparam int BLK        = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [3:0] phase_active = '0;
    logic [3:0] phase_trip = '0;
    logic [3:0] gate;

    int n_chk = 0;
    int n_fail = 0;

    phase_chopper #(
        .CLK_HZ    (1_000_000),
        .PWM_HZ    (50_000),
        .BLANK_CYC (BLK)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .phase_active (phase_active),
        .phase_trip   (phase_trip),
        .gate         (gate)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [3:0] exp);
        n_chk++;
        if (gate !== exp) begin
            n_fail++;
            $display("FAIL %s: gate=%b expected %b at %0t", req, gate, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reset, then release with enable high; returns just after edge E0.
    task automatic start_run(input logic [3:0] act, input logic [3:0] trp);
        rst_n = 1'b0;
        enable = 1'b1;
        phase_active = act;
        phase_trip = trp;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        enable = 1'b1;
        phase_active = 4'b1111;
        phase_trip = 4'b0000;
        step(3);
        chk("R1 gates off in reset", 4'b0000);
        rst_n = 1'b1;
        step(1);
        chk("R1 first edge after release starts period", 4'b0000);
    endtask

    task automatic t_trip_latch();
        start_run(4'b0001, 4'b0001);
        chk("R2 A on at start", 4'b0001);
        step(BLK);
        chk("R6 A held through blanking", 4'b0001);
        step(1);
        chk("R5 A off after blanking trip", 4'b0000);
        phase_trip = 4'b0000;
        step(PER - BLK - 2);
        chk("R5 A stays off to period end", 4'b0000);
        step(1);
        chk("R2 A back on at next start", 4'b0001);
    endtask

    task automatic t_blanking();
        start_run(4'b0001, 4'b0000);
        phase_trip = 4'b0001;
        step(BLK);
        phase_trip = 4'b0000;
        step(1);
        chk("R6 trip inside blanking ignored", 4'b0001);
        step(PER - BLK - 2);
        chk("R6 A on for whole period", 4'b0001);
    endtask

    task automatic t_independent();
        start_run(4'b0101, 4'b0100);
        chk("R2 A and B on at start", 4'b0101);
        step(BLK + 1);
        chk("R7 only B tripped", 4'b0001);
    endtask

    task automatic t_inactive();
        start_run(4'b0000, 4'b1111);
        chk("R4 nothing active at start", 4'b0000);
        step(PER - 1);
        chk("R4 nothing active at period end", 4'b0000);
        start_run(4'b1000, 4'b0011);
        step(BLK + 2);
        chk("R4 inactive trips do not disturb BB", 4'b1000);
    endtask

    task automatic t_active_midperiod();
        start_run(4'b0001, 4'b0000);
        step(5);
        phase_active = 4'b1000;
        step(1);
        chk("R3 mid-period active change ignored", 4'b0001);
        step(PER - 7);
        chk("R3 old selection held to period end", 4'b0001);
        step(1);
        chk("R3 new selection at next start", 4'b1000);
    endtask

    task automatic t_enable();
        start_run(4'b0101, 4'b0000);
        step(5);
        enable = 1'b0;
        #1;
        chk("R8 enable low forces gates off at once", 4'b0000);
        phase_active = 4'b1010;
        phase_trip = 4'b1111;
        step(5);
        chk("R8 inputs ignored while disabled", 4'b0000);
        phase_trip = 4'b0000;
        enable = 1'b1;
        step(1);
        chk("R9 resume starts fresh period", 4'b1010);
        step(PER - 1);
        chk("R9 resumed period lasts full length", 4'b1010);
    endtask

    task automatic t_pairs();
        start_run(4'b0111, 4'b0000);
        chk("R10 A/AB both requested, B alone", 4'b0100);
        start_run(4'b1111, 4'b0000);
        chk("R10 both pairs contended", 4'b0000);
        step(PER);
        chk("R10 contention persists next period", 4'b0000);
    endtask

    initial begin
        step(1);
        t_reset();
        t_trip_latch();
        t_blanking();
        t_independent();
        t_inactive();
        t_active_midperiod();
        t_enable();
        t_pairs();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule